// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

The block holds one free-running main up-counter and a set of comparator channels. Each channel watches the counter and raises an interrupt when the counter reaches exactly the value held in its comparator. A channel can run as a one-shot alarm or as a periodic tick. In periodic mode the comparator advances by a programmed period on every match. Each channel can also be told to compare only the low half of the counter, and its comparator then wraps at 2^32.

Software drives the block through a flat 32-bit register space with single-cycle writes and combinational reads. Global registers give an identity word, the tick period in femtoseconds, a run/route control word, a sticky status word and the two halves of the counter. Each channel has a control word and two comparator halves. A routing option moves channels 0 and 1 off their own interrupt lines and onto two fixed legacy lines, a system tick and a clock-chip tick.

Top module: `evtimer_top`

## Requirements
- R1: The identity word at 0x00 reads channel count minus one in bits [4:0], 1 in bit 8 when the counter is wider than 32 bits, 1 in bit 9 when legacy routing is available, and the revision in bits [15:12]. The word at 0x04 reads the constant tick period in femtoseconds.
- R2: After reset the control word (0x08), the status word (0x0C) and both counter halves read 0, every interrupt output is low, each channel control word shows only its read-only capability bits, and each comparator reads all ones.
- R3: While bit 0 (run) of the control word at 0x08 is 1, the counter increases by exactly one on every clock.
- R4: While run is 0 the counter holds its value. Writes to 0x10 (low half) and 0x14 (high half) load that half. A write takes priority over the increment.
- R5: A channel whose control word has bit 0 (level) clear gives a one-clock pulse on its line in the clock after the counter equals its comparator. A comparator value that the counter has already passed produces no event.
- R6: A channel whose control bit 1 (enable) is 0 produces no event.
- R7: Channel i sits at base 0x20+0x20*i: control at +0, comparator low at +4, comparator high at +8. A comparator write takes effect two clocks after the write clock edge. Reads return the value that is in effect.
- R8: A comparator write made while control bit 4 (value-set) is 1 loads the match value, and value-set then reads 0. With bit 2 (periodic) set and value-set clear, a comparator write loads the period. Each match then adds the period to the comparator.
- R9: Bit 3 reads 1 on channels that can run periodically, and only those channels accept a 1 in bit 2. Bit 6 is a read-only message-capable flag. Writes to bits 3 and 6 have no effect.
- R10: With control bit 5 (32-bit) set, a channel matches on the low 32 counter bits only. Its comparator wraps modulo 2^32 when the period is added, its comparator high half reads 0, and writes to the high half are ignored.
- R11: In level mode a match sets the channel's bit in the status word, and the channel line stays high while that bit is 1. Writing 1 to the bit clears it; writing 0 has no effect.
- R12: While bit 1 of 0x08 (legacy route) is 1, channel 0 drives irq_tick, channel 1 drives irq_rtc, and irq_chan[1:0] stay low. While it is 0, irq_tick and irq_rtc stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one write per clock |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W/2 | Write data |
| bus_rdata | output | CNT_W/2 | Combinational read data for bus_addr |
| irq_chan | output | N_CHAN | Per-channel interrupt lines |
| irq_tick | output | 1 | Legacy system-tick line (channel 0 when routed) |
| irq_rtc | output | 1 | Legacy clock-chip line (channel 1 when routed) |

## Verification
The bound checker checks on every clock that the counter steps by one or holds as run dictates, that legacy routing masks or idles the right lines, that value-set drops after a comparator write, and that status bits rise only from a level-mode match and fall on write-one-to-clear. The exact clock of each match pulse, the two-clock comparator latency, the periodic spacing, the 32-bit wrap and the silence of passed or disabled comparators depend on stimulus history. Only the bench's scenarios show them, including a sweep of comparator values against the expected pulse clock.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

    // Global register byte offsets
    localparam int unsigned OFS_ID     = 'h00;
    localparam int unsigned OFS_PERIOD = 'h04;
    localparam int unsigned OFS_GCFG   = 'h08;
    localparam int unsigned OFS_STAT   = 'h0C;
    localparam int unsigned OFS_CNT_LO = 'h10;
    localparam int unsigned OFS_CNT_HI = 'h14;

    // Channel window layout
    localparam int unsigned CH_SH      = 5;
    localparam int unsigned CH_STRIDE  = 1 << CH_SH;
    localparam int unsigned CH_BASE    = 'h20;
    localparam int unsigned SUB_CFG    = 'h0;
    localparam int unsigned SUB_CMP_LO = 'h4;
    localparam int unsigned SUB_CMP_HI = 'h8;

    // Control-word bit positions
    localparam int unsigned GB_RUN = 0;
    localparam int unsigned GB_LEG = 1;

    localparam int unsigned CB_LEVEL  = 0;
    localparam int unsigned CB_EN     = 1;
    localparam int unsigned CB_PER    = 2;
    localparam int unsigned CB_PERCAP = 3;
    localparam int unsigned CB_VSET   = 4;
    localparam int unsigned CB_F32    = 5;
    localparam int unsigned CB_MSGCAP = 6;

    // Comparator write latency in clocks
    localparam int unsigned WR_LAT = 2;

    typedef struct packed {
        logic f32;
        logic vset;
        logic per;
        logic en;
        logic level;
    } chan_ctl_t;

    typedef struct packed {
        logic vld;
        logic hi;
        logic to_per;
    } cmp_wr_t;

    function automatic logic [15:0] mk_id(input int unsigned n_chan,
                                          input bit wide, input bit leg,
                                          input int unsigned rev);
        logic [15:0] w;
        w        = '0;
        w[4:0]   = 5'(n_chan - 1);
        w[8]     = wide;
        w[9]     = leg;
        w[15:12] = 4'(rev);
        return w;
    endfunction

endpackage

// File: rtl/evtimer_counter.sv
module evtimer_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   cnt
);
    localparam int unsigned HALF_W = CNT_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[HALF_W-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:HALF_W] <= wdata;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evtimer_chan.sv
module evtimer_chan
    import evtimer_pkg::*;
#(
    parameter int unsigned CNT_W   = 64,
    parameter bit          PER_CAP = 1'b1,
    parameter bit          MSG_CAP = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               cfg_wr,
    input  logic               cmp_lo_wr,
    input  logic               cmp_hi_wr,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W/2-1:0] cfg_rd,
    output logic [CNT_W/2-1:0] cmp_lo_rd,
    output logic [CNT_W/2-1:0] cmp_hi_rd,
    output logic               evt,
    output logic               level,
    output logic               en,
    output logic               vset
);
    localparam int unsigned HALF_W = CNT_W / 2;

    chan_ctl_t         ctl;
    logic [CNT_W-1:0]  cmp_q, per_q, cmp_d, per_d;
    cmp_wr_t           stg [WR_LAT];
    logic [HALF_W-1:0] stg_data [WR_LAT];
    cmp_wr_t           ent;
    logic              cmp_wr, eq_lo, eq_hi;

    assign cmp_wr = cmp_lo_wr | cmp_hi_wr;

    // New staging entry: destination fixed by the mode at write time
    always_comb begin
        ent.vld    = cmp_wr && !(cmp_hi_wr && ctl.f32);
        ent.hi     = cmp_hi_wr;
        ent.to_per = ctl.per && !ctl.vset;
    end

    always_comb begin
        eq_lo = cnt[HALF_W-1:0] == cmp_q[HALF_W-1:0];
        eq_hi = cnt[CNT_W-1:HALF_W] == cmp_q[CNT_W-1:HALF_W];
        evt   = ctl.en && run && eq_lo && (ctl.f32 || eq_hi);

        cmp_d = cmp_q;
        per_d = per_q;
        if (evt && ctl.per) begin
            cmp_d = cmp_q + per_q;
            if (ctl.f32) cmp_d[CNT_W-1:HALF_W] = '0;
        end
        if (stg[WR_LAT-1].vld) begin
            if (stg[WR_LAT-1].to_per) begin
                if (stg[WR_LAT-1].hi) per_d[CNT_W-1:HALF_W] = stg_data[WR_LAT-1];
                else                  per_d[HALF_W-1:0]     = stg_data[WR_LAT-1];
            end else begin
                if (stg[WR_LAT-1].hi) cmp_d[CNT_W-1:HALF_W] = stg_data[WR_LAT-1];
                else                  cmp_d[HALF_W-1:0]     = stg_data[WR_LAT-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            cmp_q <= '1;
            per_q <= '0;
            for (int k = 0; k < WR_LAT; k++) begin
                stg[k]      <= '0;
                stg_data[k] <= '0;
            end
        end else begin
            cmp_q       <= cmp_d;
            per_q       <= per_d;
            stg[0]      <= ent;
            stg_data[0] <= wdata;
            for (int k = 1; k < WR_LAT; k++) begin
                stg[k]      <= stg[k-1];
                stg_data[k] <= stg_data[k-1];
            end
            if (cfg_wr) begin
                ctl.level <= wdata[CB_LEVEL];
                ctl.en    <= wdata[CB_EN];
                ctl.per   <= PER_CAP && wdata[CB_PER];
                ctl.vset  <= wdata[CB_VSET];
                ctl.f32   <= wdata[CB_F32];
            end else if (cmp_wr && ctl.vset) begin
                ctl.vset <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rd            = '0;
        cfg_rd[CB_LEVEL]  = ctl.level;
        cfg_rd[CB_EN]     = ctl.en;
        cfg_rd[CB_PER]    = ctl.per;
        cfg_rd[CB_PERCAP] = PER_CAP;
        cfg_rd[CB_VSET]   = ctl.vset;
        cfg_rd[CB_F32]    = ctl.f32;
        cfg_rd[CB_MSGCAP] = MSG_CAP;
        cmp_lo_rd         = cmp_q[HALF_W-1:0];
        cmp_hi_rd         = ctl.f32 ? '0 : cmp_q[CNT_W-1:HALF_W];
    end

    assign level = ctl.level;
    assign en    = ctl.en;
    assign vset  = ctl.vset;
endmodule

// File: rtl/evtimer_glob.sv
module evtimer_glob
    import evtimer_pkg::*;
#(
    parameter int unsigned N_CHAN = 3,
    parameter int unsigned HALF_W = 32,
    parameter bit          ROUTE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gcfg_wr,
    input  logic              stat_wr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [N_CHAN-1:0] evt,
    input  logic [N_CHAN-1:0] level,
    output logic              run,
    output logic              legacy,
    output logic [N_CHAN-1:0] status,
    output logic [N_CHAN-1:0] irq_chan,
    output logic              irq_tick,
    output logic              irq_rtc
);
    logic [N_CHAN-1:0] pulse_q, clr, raw;

    assign clr = stat_wr ? wdata[N_CHAN-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            legacy  <= 1'b0;
            status  <= '0;
            pulse_q <= '0;
        end else begin
            if (gcfg_wr) begin
                run    <= wdata[GB_RUN];
                legacy <= ROUTE && wdata[GB_LEG];
            end
            status  <= (status & ~clr) | (evt & level);
            pulse_q <= evt & ~level;
        end
    end

    always_comb begin
        for (int i = 0; i < N_CHAN; i++)
            raw[i] = level[i] ? status[i] : pulse_q[i];
    end

    generate
        if (ROUTE) begin : g_route
            always_comb begin
                irq_chan = raw;
                irq_tick = 1'b0;
                irq_rtc  = 1'b0;
                if (legacy) begin
                    irq_tick    = raw[0];
                    irq_rtc     = raw[1];
                    irq_chan[0] = 1'b0;
                    irq_chan[1] = 1'b0;
                end
            end
        end else begin : g_direct
            assign irq_chan = raw;
            assign irq_tick = 1'b0;
            assign irq_rtc  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int unsigned N_CHAN       = 3,
    parameter int unsigned CNT_W        = 64,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned PERIOD_FS    = 100000000,
    parameter int unsigned REV          = 1,
    parameter bit          LEG_CAP      = 1'b1,
    parameter int unsigned PER_CAP_MASK = 'h3,
    parameter int unsigned MSG_CAP_MASK = 'h4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W/2-1:0] bus_wdata,
    output logic [CNT_W/2-1:0] bus_rdata,
    output logic [N_CHAN-1:0]  irq_chan,
    output logic               irq_tick,
    output logic               irq_rtc
);
    localparam int unsigned HALF_W = CNT_W / 2;
    localparam bit          ROUTE  = LEG_CAP && (N_CHAN >= 2);
    localparam logic [15:0] ID_W   = mk_id(N_CHAN, CNT_W > 32, ROUTE, REV);

    logic               run, legacy;
    logic [CNT_W-1:0]   cnt;
    logic [N_CHAN-1:0]  status;
    logic               gcfg_wr, stat_wr, cnt_wr_lo, cnt_wr_hi;
    logic [N_CHAN-1:0]  ch_sel, ch_evt, ch_level, ch_en, ch_vset, ch_cmp_wr;
    logic [HALF_W-1:0]  ch_cfg_rd [N_CHAN];
    logic [HALF_W-1:0]  ch_lo_rd  [N_CHAN];
    logic [HALF_W-1:0]  ch_hi_rd  [N_CHAN];
    logic [CH_SH-1:0]   sub;

    assign sub       = bus_addr[CH_SH-1:0];
    assign gcfg_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_GCFG));
    assign stat_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign cnt_wr_lo = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign cnt_wr_hi = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI));

    evtimer_counter #(.CNT_W(CNT_W)) counter_i (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .wr_lo (cnt_wr_lo),
        .wr_hi (cnt_wr_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    generate
        for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
            localparam int unsigned BASE_I = CH_BASE + i * CH_STRIDE;
            logic cfg_wr_i, lo_wr_i, hi_wr_i;

            assign ch_sel[i]    = (bus_addr >> CH_SH) == ADDR_W'(BASE_I >> CH_SH);
            assign cfg_wr_i     = bus_wr && ch_sel[i] && (sub == CH_SH'(SUB_CFG));
            assign lo_wr_i      = bus_wr && ch_sel[i] && (sub == CH_SH'(SUB_CMP_LO));
            assign hi_wr_i      = bus_wr && ch_sel[i] && (sub == CH_SH'(SUB_CMP_HI));
            assign ch_cmp_wr[i] = lo_wr_i | hi_wr_i;

            evtimer_chan #(
                .CNT_W   (CNT_W),
                .PER_CAP (PER_CAP_MASK[i]),
                .MSG_CAP (MSG_CAP_MASK[i])
            ) chan_i (
                .clk       (clk),
                .rst       (rst),
                .run       (run),
                .cnt       (cnt),
                .cfg_wr    (cfg_wr_i),
                .cmp_lo_wr (lo_wr_i),
                .cmp_hi_wr (hi_wr_i),
                .wdata     (bus_wdata),
                .cfg_rd    (ch_cfg_rd[i]),
                .cmp_lo_rd (ch_lo_rd[i]),
                .cmp_hi_rd (ch_hi_rd[i]),
                .evt       (ch_evt[i]),
                .level     (ch_level[i]),
                .en        (ch_en[i]),
                .vset      (ch_vset[i])
            );
        end
    endgenerate

    evtimer_glob #(
        .N_CHAN (N_CHAN),
        .HALF_W (HALF_W),
        .ROUTE  (ROUTE)
    ) glob_i (
        .clk      (clk),
        .rst      (rst),
        .gcfg_wr  (gcfg_wr),
        .stat_wr  (stat_wr),
        .wdata    (bus_wdata),
        .evt      (ch_evt),
        .level    (ch_level),
        .run      (run),
        .legacy   (legacy),
        .status   (status),
        .irq_chan (irq_chan),
        .irq_tick (irq_tick),
        .irq_rtc  (irq_rtc)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_ID))          bus_rdata = HALF_W'(ID_W);
        else if (bus_addr == ADDR_W'(OFS_PERIOD)) bus_rdata = HALF_W'(PERIOD_FS);
        else if (bus_addr == ADDR_W'(OFS_GCFG)) begin
            bus_rdata[GB_RUN] = run;
            bus_rdata[GB_LEG] = legacy;
        end
        else if (bus_addr == ADDR_W'(OFS_STAT))   bus_rdata[N_CHAN-1:0] = status;
        else if (bus_addr == ADDR_W'(OFS_CNT_LO)) bus_rdata = cnt[HALF_W-1:0];
        else if (bus_addr == ADDR_W'(OFS_CNT_HI)) bus_rdata = cnt[CNT_W-1:HALF_W];
        for (int i = 0; i < N_CHAN; i++) begin
            if (ch_sel[i]) begin
                if (sub == CH_SH'(SUB_CFG))         bus_rdata = ch_cfg_rd[i];
                else if (sub == CH_SH'(SUB_CMP_LO)) bus_rdata = ch_lo_rd[i];
                else if (sub == CH_SH'(SUB_CMP_HI)) bus_rdata = ch_hi_rd[i];
            end
        end
    end
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
    parameter int unsigned N_CHAN = 3,
    parameter int unsigned CNT_W  = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic               legacy,
    input logic [CNT_W-1:0]   cnt,
    input logic               cnt_wr,
    input logic               stat_wr,
    input logic [CNT_W/2-1:0] wdata,
    input logic [N_CHAN-1:0]  status,
    input logic [N_CHAN-1:0]  ch_evt,
    input logic [N_CHAN-1:0]  ch_level,
    input logic [N_CHAN-1:0]  ch_en,
    input logic [N_CHAN-1:0]  ch_vset,
    input logic [N_CHAN-1:0]  ch_cmp_wr,
    input logic [N_CHAN-1:0]  irq_chan,
    input logic               irq_tick,
    input logic               irq_rtc
);
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

    assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));

    assert_legacy_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !legacy |-> (!irq_tick && !irq_rtc));

    generate
        if (N_CHAN >= 2) begin : g_leg
            assert_legacy_mask_R12: assert property (@(posedge clk) disable iff (rst)
                legacy |-> (irq_chan[1:0] == 2'b00));
        end
        for (genvar i = 0; i < N_CHAN; i++) begin : g_ch
            assert_vset_clear_R8: assert property (@(posedge clk) disable iff (rst)
                ch_cmp_wr[i] |=> !ch_vset[i]);

            assert_level_source_R11: assert property (@(posedge clk) disable iff (rst)
                $rose(status[i]) |-> $past(run && ch_en[i] && ch_level[i]));

            assert_w1c_R11: assert property (@(posedge clk) disable iff (rst)
                (stat_wr && wdata[i] && !(ch_evt[i] && ch_level[i])) |=> !status[i]);
        end
    endgenerate
endmodule

bind evtimer_top evtimer_chk #(.N_CHAN(N_CHAN), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .legacy    (legacy),
    .cnt       (cnt),
    .cnt_wr    (cnt_wr_lo | cnt_wr_hi),
    .stat_wr   (stat_wr),
    .wdata     (bus_wdata),
    .status    (status),
    .ch_evt    (ch_evt),
    .ch_level  (ch_level),
    .ch_en     (ch_en),
    .ch_vset   (ch_vset),
    .ch_cmp_wr (ch_cmp_wr),
    .irq_chan  (irq_chan),
    .irq_tick  (irq_tick),
    .irq_rtc   (irq_rtc)
);

// File: tb/evtimer_top_tb_top.sv
module evtimer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [2:0]  irq_chan;
    logic        irq_tick, irq_rtc;

    int n_chk = 0;
    int n_fail = 0;
    int first_seen [5];
    int hits [5];

    always #10 clk = ~clk;

    evtimer_top dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_chan(irq_chan), .irq_tick(irq_tick), .irq_rtc(irq_rtc)
    );

    localparam logic [7:0] A_ID = 8'h00, A_PER = 8'h04, A_GCFG = 8'h08,
                           A_STAT = 8'h0C, A_CLO = 8'h10, A_CHI = 8'h14;

    function automatic logic [7:0] chb(input int i);
        return 8'(8'h20 + 8'h20 * i);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // Observe lines 0..2 = irq_chan, 3 = irq_tick, 4 = irq_rtc
    task automatic window(input int n);
        logic [4:0] obs;
        for (int l = 0; l < 5; l++) begin first_seen[l] = 0; hits[l] = 0; end
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); @(negedge clk);
            obs = {irq_rtc, irq_tick, irq_chan};
            for (int l = 0; l < 5; l++)
                if (obs[l]) begin
                    hits[l]++;
                    if (first_seen[l] == 0) first_seen[l] = i;
                end
        end
    endtask

    task automatic quiesce;
        wr(A_GCFG, 0);
        for (int i = 0; i < 3; i++) wr(chb(i), 0);
        wr(A_STAT, 32'h7);
        wr(A_CLO, 0);
        wr(A_CHI, 0);
        idle(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, a0, a1;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        rd(A_GCFG, d);   check("R2 gcfg", d, 0);
        rd(A_STAT, d);   check("R2 status", d, 0);
        rd(A_CLO, d);    check("R2 cnt lo", d, 0);
        rd(A_CHI, d);    check("R2 cnt hi", d, 0);
        rd(chb(0), d);   check("R2 ch0 cfg", d, 32'h08);
        rd(chb(2), d);   check("R2 ch2 cfg", d, 32'h40);
        rd(chb(1)+4, d); check("R2 ch1 cmp lo", d, 32'hFFFF_FFFF);
        check("R2 irq lines", {27'd0, irq_rtc, irq_tick, irq_chan}, 0);

        // R1 identity and period
        rd(A_ID, d);  check("R1 id", d, 32'h0000_1302);
        rd(A_PER, d); check("R1 period", d, 32'd100000000);

        // R7 comparator write latency
        wr(chb(2)+4, 32'h55);
        rd(chb(2)+4, d); check("R7 after edge W", d, 32'hFFFF_FFFF);
        idle(1);
        rd(chb(2)+4, d); check("R7 after W+1", d, 32'hFFFF_FFFF);
        idle(1);
        rd(chb(2)+4, d); check("R7 after W+2", d, 32'h55);

        // R9 capability bits
        wr(chb(2), 32'h4E);
        rd(chb(2), d); check("R9 ch2 no periodic", d, 32'h42);
        wr(chb(0), 32'h4C);
        rd(chb(0), d); check("R9 ch0 periodic", d, 32'h0C);
        quiesce();

        // R3 counting
        wr(A_GCFG, 1);
        rd(A_CLO, a0);
        idle(7);
        rd(A_CLO, a1);
        check("R3 step count", a1 - a0, 7);
        // R4 write wins while running
        wr(A_CLO, 100);
        rd(A_CLO, d); check("R4 write over run", d, 100);
        // R4 freeze and load
        wr(A_GCFG, 0);
        rd(A_CLO, a0);
        idle(5);
        rd(A_CLO, a1); check("R4 frozen", a1, a0);
        wr(A_CLO, 32'h1234); wr(A_CHI, 32'hAB);
        rd(A_CLO, d); check("R4 load lo", d, 32'h1234);
        rd(A_CHI, d); check("R4 load hi", d, 32'hAB);
        quiesce();

        // R5 exact-equality sweep, one-shot edge mode on channel 0
        for (int c = 1; c <= 12; c++) begin
            wr(A_GCFG, 0); wr(A_CLO, 0); wr(A_CHI, 0);
            wr(chb(0), 32'h2);
            wr(chb(0)+8, 0); wr(chb(0)+4, 32'(c));
            idle(3);
            wr(A_GCFG, 1);
            window(c + 8);
            check($sformatf("R5 first pulse cmp=%0d", c), 32'(first_seen[0]), 32'(c + 1));
            check($sformatf("R5 single pulse cmp=%0d", c), 32'(hits[0]), 1);
            check($sformatf("R12 legacy idle cmp=%0d", c), 32'(hits[3] + hits[4]), 0);
        end
        quiesce();

        // R5 passed value never fires
        wr(chb(0), 32'h2); wr(chb(0)+8, 0); wr(chb(0)+4, 5);
        wr(A_CLO, 10);
        idle(3);
        wr(A_GCFG, 1);
        window(20);
        check("R5 passed value", 32'(hits[0]), 0);
        quiesce();

        // R6 disabled channel
        wr(chb(0), 32'h0); wr(chb(0)+8, 0); wr(chb(0)+4, 5);
        idle(3);
        wr(A_GCFG, 1);
        window(15);
        check("R6 disabled", 32'(hits[0]), 0);
        quiesce();

        // R8 periodic with value-set on channel 1
        wr(chb(1), 32'h16); wr(chb(1)+8, 0);
        wr(chb(1), 32'h16); wr(chb(1)+4, 10);
        rd(chb(1), d); check("R8 value-set cleared", d, 32'h0E);
        wr(chb(1)+4, 7);
        idle(3);
        wr(A_GCFG, 1);
        window(40);
        check("R8 first periodic", 32'(first_seen[1]), 11);
        check("R8 periodic count", 32'(hits[1]), 5);
        quiesce();

        // R10 32-bit mode: low-half match with high counter half nonzero
        wr(chb(0), 32'h22); wr(chb(0)+4, 3); wr(chb(0)+8, 32'h5);
        wr(A_CHI, 1);
        idle(3);
        rd(chb(0)+8, d); check("R10 cmp hi reads 0", d, 0);
        wr(A_GCFG, 1);
        window(8);
        check("R10 low-half match", 32'(first_seen[0]), 4);
        quiesce();

        // R10 32-bit periodic wrap on channel 1
        wr(chb(1), 32'h36); wr(chb(1)+4, 32'hFFFF_FFFE); wr(chb(1)+4, 4);
        wr(A_CLO, 32'hFFFF_FFFA);
        idle(3);
        wr(A_GCFG, 1);
        window(12);
        check("R10 wrap first", 32'(first_seen[1]), 5);
        check("R10 wrap count", 32'(hits[1]), 2);
        wr(A_GCFG, 0);
        rd(chb(1)+4, d); check("R10 cmp wrapped", d, 32'hA);
        rd(chb(1)+8, d); check("R10 cmp hi zero", d, 0);
        quiesce();

        // R11 level mode and write-one-to-clear on channel 2
        wr(chb(2), 32'h3); wr(chb(2)+8, 0); wr(chb(2)+4, 5);
        idle(3);
        wr(A_GCFG, 1);
        window(10);
        check("R11 level first", 32'(first_seen[2]), 6);
        check("R11 level held", 32'(hits[2]), 5);
        wr(A_GCFG, 0);
        rd(A_STAT, d); check("R11 status set", d, 32'h4);
        wr(A_STAT, 32'h3);
        rd(A_STAT, d); check("R11 zero write no clear", d, 32'h4);
        check("R11 line still high", 32'(irq_chan[2]), 1);
        wr(A_STAT, 32'h4);
        rd(A_STAT, d); check("R11 cleared", d, 0);
        check("R11 line low", 32'(irq_chan[2]), 0);
        quiesce();

        // R12 legacy routing
        wr(chb(0), 32'h2); wr(chb(0)+8, 0); wr(chb(0)+4, 4);
        wr(chb(1), 32'h2); wr(chb(1)+8, 0); wr(chb(1)+4, 6);
        idle(3);
        wr(A_GCFG, 32'h3);
        window(10);
        check("R12 tick pulse", 32'(first_seen[3]), 5);
        check("R12 rtc pulse", 32'(first_seen[4]), 7);
        check("R12 ch0/ch1 masked", 32'(hits[0] + hits[1]), 0);
        rd(A_GCFG, d); check("R12 gcfg readback", d, 32'h3);
        quiesce();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule